// File: doc/BRIEF.md
# DSP Status Flag Register

This block holds the condition flags that a DSP core's branch logic tests. It has nine one-bit flags. The core reads them as a single word every cycle. Some of the flags are tied to the outside world. Two external input pins are passed through a synchroniser and then appear as the two lowest flags. Two flags that the core writes are driven straight out on two output pins.

One further flag marks audio framing. It is set when the serial audio receiver signals that a new sample is ready, which happens on each falling edge of that receiver's word-select line. The flag then stays set until the core acknowledges it with a write-one-to-clear.

Core writes go through a fixed mask. The mask stops the core from changing the pin-driven flags or the event flag directly. The remaining flags, including the two that drive the output pins, can be written freely by the core.

Top module: `dsp_flag_reg`

## Requirements
- R1: A synchronous active-high reset clears all nine bits of `rd_flags` to zero and drives both bits of `pin_out` low.
- R2: `pin_in[i]` appears on `rd_flags[i]` (i = 0, 1) on the second rising clock edge after it is sampled, through a two-stage synchroniser.
- R3: When `wr_en` is high, bits 2 to 7 of `rd_flags` take the values of `wr_data[7:2]` at the next clock edge. Bits 0 and 1 are not changed by a write.
- R4: `pin_out[0]` always equals `rd_flags[3]`, and `pin_out[1]` always equals `rd_flags[4]`. Both come from registered state.
- R5: A high `smp_ready` sets `rd_flags[8]` at the next clock edge. The bit then stays set until it is cleared as described in R6.
- R6: `wr_en` high with `wr_data[8]` = 1 clears `rd_flags[8]`. `wr_en` high with `wr_data[8]` = 0 leaves that bit unchanged.
- R7: If `smp_ready` and a clear of `rd_flags[8]` occur in the same cycle, `rd_flags[8]` ends up set.
- R8: While `wr_en` is low, bits 2 to 7 of `rd_flags` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 2 | Asynchronous external condition inputs |
| smp_ready | input | 1 | One-cycle pulse from the audio receiver when a new sample is ready |
| wr_en | input | 1 | Core write strobe |
| wr_data | input | 9 | Core write data. Bit 8 is a write-one-to-clear for the event flag. |
| rd_flags | output | 9 | Full flag word for the branch logic |
| pin_out | output | 2 | External outputs driven from flags 3 and 4 |

## Verification
The bench builds the block with its default parameters: nine flags, two input pins on bits 0–1, two output flags on bits 3–4, the event flag on bit 8, and a two-stage synchroniser. With these values, every boundary between masked and writable bits can be reached. So can the exact two-edge synchroniser latency and the collision between a sample event and a clear in the same cycle. All of these are tested directly at the ports.

// File: rtl/dsp_flag_pkg.sv
package dsp_flag_pkg;

  // Default layout of the flag word
  localparam int unsigned DEF_FLAG_W   = 9;
  localparam int unsigned DEF_N_IN     = 2;
  localparam int unsigned DEF_N_OUT    = 2;
  localparam int unsigned DEF_OUT_BASE = 3;
  localparam int unsigned DEF_EVT_BIT  = 8;
  localparam int unsigned DEF_SYNC     = 2;

  // Bits the core may write: everything except pin-fed bits and the event bit
  function automatic logic [31:0] core_mask(input int unsigned w,
                                            input int unsigned n_in,
                                            input int unsigned evt);
    logic [31:0] m;
    m = '0;
    for (int unsigned i = 0; i < w; i++) begin
      m[i] = (i >= n_in) && (i != evt);
    end
    return m;
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/core_flag_bank.sv
module core_flag_bank #(
  parameter int unsigned W    = 9,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Bits outside MASK stay zero; they are filled in by other sources
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d & MASK;
  end

endmodule

// File: rtl/event_flag.sv
module event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);

  // Set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

endmodule

// File: rtl/dsp_flag_reg.sv
module dsp_flag_reg
  import dsp_flag_pkg::*;
#(
  parameter int unsigned FLAG_W      = DEF_FLAG_W,
  parameter int unsigned N_IN        = DEF_N_IN,
  parameter int unsigned N_OUT       = DEF_N_OUT,
  parameter int unsigned OUT_BASE    = DEF_OUT_BASE,
  parameter int unsigned EVT_BIT     = DEF_EVT_BIT,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   pin_in,
  input  logic              smp_ready,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] rd_flags,
  output logic [N_OUT-1:0]  pin_out
);

  localparam logic [31:0]       MASK32  = core_mask(FLAG_W, N_IN, EVT_BIT);
  localparam logic [FLAG_W-1:0] WR_MASK = MASK32[FLAG_W-1:0];

  logic [N_IN-1:0]   pin_sync;
  logic [FLAG_W-1:0] bank_q;
  logic              evt_q;
  logic [FLAG_W-1:0] ext_bits;

  flag_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  core_flag_bank #(.W(FLAG_W), .MASK(WR_MASK)) u_bank (
    .clk(clk), .rst(rst), .we(wr_en), .d(wr_data), .q(bank_q)
  );

  event_flag u_evt (
    .clk(clk), .rst(rst), .set(smp_ready),
    .clr(wr_en & wr_data[EVT_BIT]), .q(evt_q)
  );

  always_comb begin
    ext_bits              = '0;
    ext_bits[N_IN-1:0]    = pin_sync;
    ext_bits[EVT_BIT]     = evt_q;
  end

  assign rd_flags = bank_q | ext_bits;
  assign pin_out  = bank_q[OUT_BASE +: N_OUT];

endmodule

// File: rtl/dsp_flag_reg_chk.sv
module dsp_flag_reg_chk #(
  parameter int unsigned FLAG_W   = 9,
  parameter int unsigned N_IN     = 2,
  parameter int unsigned N_OUT    = 2,
  parameter int unsigned OUT_BASE = 3,
  parameter int unsigned EVT_BIT  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [N_IN-1:0]   pin_in,
  input logic              smp_ready,
  input logic              wr_en,
  input logic [FLAG_W-1:0] wr_data,
  input logic [FLAG_W-1:0] rd_flags,
  input logic [N_OUT-1:0]  pin_out
);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rd_flags == '0 && pin_out == '0));

  p_sync_delay_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> rd_flags[N_IN-1:0] == $past(pin_in, 2));

  p_write_core_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_flags[EVT_BIT-1:N_IN] == $past(wr_data[EVT_BIT-1:N_IN]));

  p_pin_mirror_r4: assert property (@(posedge clk) disable iff (rst)
    pin_out == rd_flags[OUT_BASE +: N_OUT]);

  p_event_set_r5: assert property (@(posedge clk) disable iff (rst)
    smp_ready |=> rd_flags[EVT_BIT]);

  p_event_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[EVT_BIT] && !smp_ready) |=> !rd_flags[EVT_BIT]);

  p_event_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_flags[EVT_BIT] && !(wr_en && wr_data[EVT_BIT])) |=> rd_flags[EVT_BIT]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (smp_ready && wr_en && wr_data[EVT_BIT]) |=> rd_flags[EVT_BIT]);

  p_core_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_flags[EVT_BIT-1:N_IN]));

endmodule

bind dsp_flag_reg dsp_flag_reg_chk #(
  .FLAG_W(FLAG_W), .N_IN(N_IN), .N_OUT(N_OUT),
  .OUT_BASE(OUT_BASE), .EVT_BIT(EVT_BIT)
) u_chk (
  .clk(clk), .rst(rst), .pin_in(pin_in), .smp_ready(smp_ready),
  .wr_en(wr_en), .wr_data(wr_data), .rd_flags(rd_flags), .pin_out(pin_out)
);

// File: tb/dsp_flag_reg_tb.sv
`timescale 1ns/1ps
module dsp_flag_reg_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pin_in = 2'b00;
  logic       smp_ready = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_flags;
  logic [1:0] pin_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dsp_flag_reg u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .smp_ready(smp_ready),
    .wr_en(wr_en), .wr_data(wr_data), .rd_flags(rd_flags), .pin_out(pin_out)
  );

  // {smp_ready, wr_en, wr_data[8:0], expected rd_flags[8:0]}; pins held at 2'b10
  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b1, 9'h0F8, 9'h0FA},  // R3 write bits 3..7
    {1'b0, 1'b1, 9'h001, 9'h002},  // R3 bits 0,1 protected
    {1'b1, 1'b0, 9'h000, 9'h102},  // R5 event sets
    {1'b0, 1'b0, 9'h1FF, 9'h102},  // R5 R8 hold without write
    {1'b0, 1'b1, 9'h118, 9'h01A},  // R6 clear by write-one
    {1'b1, 1'b1, 9'h100, 9'h102},  // R7 set wins over clear
    {1'b0, 1'b1, 9'h0AC, 9'h1AE},  // R6 write with bit8=0 keeps event
    {1'b0, 1'b0, 9'h055, 9'h1AE},  // R8 idle hold
    {1'b0, 1'b1, 9'h100, 9'h002}   // R6 clear, R3 clear core bits
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flags after reset", rd_flags, 9'h000);
    chk("R1 pin_out after reset", {7'd0, pin_out}, 9'h000);
    rst = 1'b0;

    pin_in = 2'b10;
    repeat (3) @(negedge clk);
    chk("R2 pins settled", {7'd0, rd_flags[1:0]}, 9'h002);

    for (int i = 0; i < NV; i++) begin
      smp_ready = VEC[i][19];
      wr_en     = VEC[i][18];
      wr_data   = VEC[i][17:9];
      @(negedge clk);
      chk($sformatf("vector %0d flags", i), rd_flags, VEC[i][8:0]);
      chk($sformatf("R4 vector %0d pin_out", i), {7'd0, pin_out},
          {7'd0, VEC[i][4], VEC[i][3]});
    end
    smp_ready = 1'b0;
    wr_en     = 1'b0;
    wr_data   = '0;

    // R2 latency: new level visible only after two edges
    pin_in = 2'b01;
    @(negedge clk);
    chk("R2 one edge still old", {7'd0, rd_flags[1:0]}, 9'h002);
    @(negedge clk);
    chk("R2 two edges new", {7'd0, rd_flags[1:0]}, 9'h001);

    // R4 both outputs high, then R1 reset mid-run
    wr_en = 1'b1; wr_data = 9'h018; smp_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; smp_ready = 1'b0;
    chk("R4 both outputs high", {7'd0, pin_out}, 9'h003);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-run flags", rd_flags, 9'h000);
    chk("R1 reset mid-run pin_out", {7'd0, pin_out}, 9'h000);
    rst = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule